// File: doc/BRIEF.md
# Dual-Rail Return-to-Zero Configurable Gate Chain

This block is a cycle-accurate logical model of a dual-rail, return-to-zero logic style. Each gate is one universal two-input multiplexer cell. It carries every signal as a pair of rails, a true rail and a complement rail. A pair with both rails at 0 is the spacer, and a pair with exactly one rail at 1 is a valid value. The cell is made into an AND, OR, XOR or MUX only by how its operand rails are steered onto its two data inputs and its select input. When both select rails are held low, the cell forces both of its outputs to 0.

Single-rail operands enter through converters that drive both rails to 0 while the evaluate phase input is low, or while that operand has not yet arrived. The converted operands feed a chain of cells: each stage combines the result of the stage before it with a fresh operand. Every stage's rail pair is registered at the block edge. This shows that the spacer wave travels down the chain and that each pair rises exactly once per evaluation. A registered flag reports when any stage resolves while one of its input pairs is still a spacer. That condition is early propagation.

Top module: `drl_chain`

## Requirements
- R1: While `rst` is high at a rising edge, every bit of `rail_t`, `rail_f` and `early` is 0 after that edge.
- R2: When `eval_en` is low, every stage pair reads 0,0 one clock later, whatever the operands, arrival bits and modes.
- R3: Stage k takes its mode from `mode[2k+1:2k]`, with 0 = AND, 1 = OR, 2 = XOR and 3 = MUX. Its operand A is the result of stage k-1, or `opnd[0]` for stage 0. Its operand B is `opnd[k+1]`. MUX yields A when B is 1 and `mdat[k]` when B is 0. The true rail of stage k carries the result one clock after the inputs are applied.
- R4: When `eval_en` is high and every `arrive` bit is high, `rail_f` equals the bitwise inverse of `rail_t` one clock later.
- R5: No stage ever shows both rails at 1.
- R6: At the first evaluation after a spacer cycle, with all operands arrived, every stage pair goes from 0,0 to exactly one rail at 1.
- R7: An operand whose `arrive` bit is low is a spacer. A stage stays 0,0 unless its operand B alone decides the result: AND with B=0, OR with B=1, or MUX with B=0. XOR and MUX with B=1 need both A and B.
- R8: `early` is 1 one clock after a cycle in which some stage resolved while its A or B pair was a spacer, and 0 otherwise.
- R9: With `eval_en` held high over consecutive cycles, the rails follow the new operands each cycle with one clock of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eval_en | input | 1 | Phase: 1 = evaluate, 0 = spacer |
| arrive | input | STAGES+1 | Per-operand arrival; 0 holds that operand in the spacer |
| opnd | input | STAGES+1 | Single-rail operands; bit 0 seeds stage 0, bit k+1 is B of stage k |
| mdat | input | STAGES | MUX data input per stage, used when B is 0 |
| mode | input | 2*STAGES | Two-bit mode per stage |
| rail_t | output | STAGES | Registered true rail of each stage |
| rail_f | output | STAGES | Registered complement rail of each stage |
| early | output | 1 | Registered early-propagation flag |

## Verification
The bench applies a spacer before every evaluation and sweeps all operand and MUX-data combinations for each uniform mode. It also sweeps mixed per-stage mode patterns and every arrival mask. A wrong XOR steering or swapped OR inputs would show up as a wrong true rail for certain operand pairs. A cell that does not force its outputs to zero would leave stale rails during the spacer cycle. Partial-arrival cases separate the B-decided results from stalled ones, so a cell that waits for both inputs, or one that resolves a need-both result early, would set a wrong rail or a wrong `early` flag. Back-to-back evaluations without a spacer check that the rails follow new data.

// File: rtl/drl_pkg.sv
package drl_pkg;
  typedef struct packed {
    logic t;
    logic f;
  } drl_t;

  typedef enum logic [1:0] {
    DRL_AND = 2'd0,
    DRL_OR  = 2'd1,
    DRL_XOR = 2'd2,
    DRL_MUX = 2'd3
  } drl_mode_e;

  // complement of a dual-rail value is a rail swap; spacer maps to spacer
  function automatic drl_t drl_inv(input drl_t v);
    drl_inv = '{t: v.f, f: v.t};
  endfunction

  function automatic logic drl_valid(input drl_t v);
    drl_valid = v.t | v.f;
  endfunction
endpackage

// File: rtl/drl_encode.sv
module drl_encode #(
  parameter int W = 1
) (
  input  logic         phase,
  input  logic [W-1:0] here,
  input  logic [W-1:0] d,
  output logic [W-1:0] q_t,
  output logic [W-1:0] q_f
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign q_t[i] = phase & here[i] &  d[i];
    assign q_f[i] = phase & here[i] & ~d[i];
  end
endmodule

// File: rtl/drl_cell.sv
module drl_cell
  import drl_pkg::*;
(
  input  drl_t ip1,
  input  drl_t ip2,
  input  drl_t sel,
  output drl_t o
);
  // select pair 0,0 turns the evaluation paths off: both outputs low
  assign o.t = (ip1.t & sel.t) | (ip2.t & sel.f) | (sel.t & sel.f);
  assign o.f = (ip1.f & sel.t) | (ip2.f & sel.f) | (sel.t & sel.f);
endmodule

// File: rtl/drl_stage.sv
module drl_stage
  import drl_pkg::*;
(
  input  drl_mode_e md,
  input  drl_t      a,
  input  drl_t      b,
  input  drl_t      m,
  output drl_t      y,
  output logic      early
);
  drl_t ip1, ip2, sel;

  always_comb begin
    sel = b;
    unique case (md)
      DRL_AND: begin ip1 = a;          ip2 = b; end
      DRL_OR:  begin ip1 = b;          ip2 = a; end
      DRL_XOR: begin ip1 = drl_inv(a); ip2 = a; end
      default: begin ip1 = a;          ip2 = m; end
    endcase
  end

  drl_cell u_cell (
    .ip1 (ip1),
    .ip2 (ip2),
    .sel (sel),
    .o   (y)
  );

  assign early = drl_valid(y) & ~(drl_valid(a) & drl_valid(b));
endmodule

// File: rtl/drl_chain.sv
module drl_chain
  import drl_pkg::*;
#(
  parameter int STAGES = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  eval_en,
  input  logic [STAGES:0]       arrive,
  input  logic [STAGES:0]       opnd,
  input  logic [STAGES-1:0]     mdat,
  input  logic [2*STAGES-1:0]   mode,
  output logic [STAGES-1:0]     rail_t,
  output logic [STAGES-1:0]     rail_f,
  output logic                  early
);
  localparam int NOPS = STAGES + 1;

  logic [NOPS-1:0]   op_t, op_f;
  logic [STAGES-1:0] md_t, md_f;
  logic [STAGES-1:0] y_t, y_f, early_v;

  drl_encode #(.W(NOPS)) u_enc_op (
    .phase (eval_en),
    .here  (arrive),
    .d     (opnd),
    .q_t   (op_t),
    .q_f   (op_f)
  );

  drl_encode #(.W(STAGES)) u_enc_md (
    .phase (eval_en),
    .here  ({STAGES{1'b1}}),
    .d     (mdat),
    .q_t   (md_t),
    .q_f   (md_f)
  );

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    drl_t a_in, b_in, m_in, y_out;
    if (k == 0) begin : g_head
      assign a_in = '{t: op_t[0], f: op_f[0]};
    end else begin : g_link
      assign a_in = '{t: y_t[k-1], f: y_f[k-1]};
    end
    assign b_in = '{t: op_t[k+1], f: op_f[k+1]};
    assign m_in = '{t: md_t[k], f: md_f[k]};

    drl_stage u_stage (
      .md    (drl_mode_e'(mode[2*k +: 2])),
      .a     (a_in),
      .b     (b_in),
      .m     (m_in),
      .y     (y_out),
      .early (early_v[k])
    );
    assign y_t[k] = y_out.t;
    assign y_f[k] = y_out.f;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rail_t <= '0;
      rail_f <= '0;
      early  <= 1'b0;
    end else begin
      rail_t <= y_t;
      rail_f <= y_f;
      early  <= |early_v;
    end
  end
endmodule

// File: rtl/drl_chain_chk.sv
module drl_chain_chk #(
  parameter int STAGES = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                eval_en,
  input logic [STAGES:0]     arrive,
  input logic [STAGES-1:0]   rail_t,
  input logic [STAGES-1:0]   rail_f,
  input logic                early
);
  localparam logic [STAGES-1:0] ALL1 = {STAGES{1'b1}};

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (rail_t == '0) && (rail_f == '0) && !early);

  a_r2_spacer_wave: assert property (@(posedge clk) disable iff (rst)
    !eval_en |=> (rail_t == '0) && (rail_f == '0));

  a_r4_complement: assert property (@(posedge clk) disable iff (rst)
    (eval_en && (&arrive)) |=> (rail_f == ~rail_t));

  a_r5_no_double_high: assert property (@(posedge clk) disable iff (rst)
    (rail_t & rail_f) == '0);

  a_r6_single_rise: assert property (@(posedge clk) disable iff (rst)
    (eval_en && (&arrive) && !$past(eval_en)) |=>
      ((rail_t ^ rail_f) == ALL1) && (($past(rail_t) | $past(rail_f)) == '0));

  a_r8_early_cause: assert property (@(posedge clk) disable iff (rst)
    early |-> ($past(eval_en) && !(&$past(arrive))));
endmodule

bind drl_chain drl_chain_chk #(.STAGES(STAGES)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .eval_en (eval_en),
  .arrive  (arrive),
  .rail_t  (rail_t),
  .rail_f  (rail_f),
  .early   (early)
);

// File: tb/sim_drl_chain.sv
`timescale 1ns/1ps
module sim_drl_chain;
  localparam int ST = 4;
  localparam int NO = ST + 1;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            eval_en = 1'b0;
  logic [NO-1:0]   arrive = '0;
  logic [NO-1:0]   opnd = '0;
  logic [ST-1:0]   mdat = '0;
  logic [2*ST-1:0] mode = '0;
  logic [ST-1:0]   rail_t, rail_f;
  logic            early;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  drl_chain #(.STAGES(ST)) u0 (
    .clk(clk), .rst(rst), .eval_en(eval_en), .arrive(arrive), .opnd(opnd),
    .mdat(mdat), .mode(mode), .rail_t(rail_t), .rail_f(rail_f), .early(early)
  );

  // ternary value: -1 = spacer, 0/1 = data
  function automatic int gate(input int md, input int a, input int b, input int m);
    if (b < 0) return -1;
    case (md)
      0: return (b == 0) ? 0 : a;
      1: return (b == 1) ? 1 : a;
      2: return (a < 0) ? -1 : (a ^ b);
      default: return (b == 1) ? a : m;
    endcase
  endfunction

  logic [ST-1:0] exp_t, exp_f;
  logic          exp_e;

  task automatic predict();
    int acc;
    exp_e = 1'b0;
    acc = (eval_en && arrive[0]) ? int'(opnd[0]) : -1;
    for (int k = 0; k < ST; k++) begin
      int b, m, r;
      b = (eval_en && arrive[k+1]) ? int'(opnd[k+1]) : -1;
      m = eval_en ? int'(mdat[k]) : -1;
      r = gate(int'(mode[2*k +: 2]), acc, b, m);
      if (r >= 0 && (acc < 0 || b < 0)) exp_e = 1'b1;
      exp_t[k] = (r == 1);
      exp_f[k] = (r == 0);
      acc = r;
    end
  endtask

  task automatic check(input string tag);
    checks++;
    if (rail_t !== exp_t || rail_f !== exp_f || early !== exp_e) begin
      failures++;
      $display("FAIL %s: got t=%b f=%b early=%b expected t=%b f=%b early=%b",
               tag, rail_t, rail_f, early, exp_t, exp_f, exp_e);
    end
  endtask

  task automatic step(input logic ev, input logic [NO-1:0] ar, input logic [NO-1:0] op,
                      input logic [ST-1:0] md, input logic [2*ST-1:0] mo, input string tag);
    logic full;
    @(negedge clk);
    eval_en = ev; arrive = ar; opnd = op; mdat = md; mode = mo;
    predict();
    full = ev && (&ar);
    @(posedge clk);
    #1;
    check(tag);
    if (full) begin
      checks++;
      if (rail_f !== ~rail_t) begin
        failures++;
        $display("FAIL R4: got f=%b expected %b", rail_f, ~rail_t);
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    exp_t = '0; exp_f = '0; exp_e = 1'b0;
    check("R1 reset");
    @(negedge clk);
    rst = 1'b0;

    // R3 R6 R2: uniform modes, exhaustive operands, spacer between evaluations
    for (int md = 0; md < 4; md++) begin
      logic [2*ST-1:0] mo;
      mo = {ST{md[1:0]}};
      for (int v = 0; v < (1 << (NO + ST)); v++) begin
        step(1'b0, '1, v[NO-1:0], v[NO+ST-1:NO], mo, "R2 spacer");
        step(1'b1, '1, v[NO-1:0], v[NO+ST-1:NO], mo, "R3 R6 eval");
      end
    end

    // R3: mixed per-stage modes
    for (int p = 0; p < 64; p++) begin
      for (int v = 0; v < 32; v++) begin
        int x;
        x = (v * 11 + p * 7) & 15;
        step(1'b0, '1, v[NO-1:0], x[ST-1:0], p[7:0] * 8'd37, "R2 spacer mixed");
        step(1'b1, '1, v[NO-1:0], x[ST-1:0], p[7:0] * 8'd37, "R3 mixed modes");
      end
    end

    // R7 R8: every arrival mask with assorted data and modes
    for (int am = 0; am < (1 << NO); am++) begin
      for (int p = 0; p < 16; p++) begin
        int v;
        v = (am * 5 + p * 9) & 31;
        step(1'b0, '1, '0, '0, '0, "R2 spacer arrival");
        step(1'b1, am[NO-1:0], v[NO-1:0], p[ST-1:0], p[7:0] * 8'd53, "R7 R8 arrival");
      end
    end

    // R2: spacer with live data and partial arrival still clears everything
    step(1'b1, '1, 5'b11111, 4'hF, 8'h55, "R9 prime");
    step(1'b0, 5'b10101, 5'b11111, 4'hF, 8'h55, "R2 live data spacer");

    // R9: back-to-back evaluations without spacer
    for (int v = 0; v < 64; v++)
      step(1'b1, '1, v[NO-1:0], v[ST+1:2], 8'hE4, "R9 back-to-back");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule